// File: doc/BRIEF.md
# Byte-Valid Write-Back Store Cache

This block is a small set-associative cache that holds only store data. It sits between the core's store path and a larger next-level cache. A store that misses claims a line at once and never fetches the old contents of that line. Instead, each byte of every line carries its own valid flag, and only the bytes that stores have written are marked valid. While a line stays resident it is the only on-chip copy of its dirty bytes.

When a new line needs a way in a full set, the victim is moved into a single eviction buffer and the new line takes its way in the same cycle. If every byte of the victim is valid, the buffer goes straight out on the write port. Otherwise the block first requests the line from the next level. The returned data passes through a per-byte multiplexer that keeps the buffer's byte wherever that byte is valid. The merged line is then written out. A store is held off while the eviction involves its set, and also when the store would need a second eviction.

Top module: `wsc_store_cache`

## Requirements
- R1: After reset every line is invalid, `st_ready` is 1, and both `rd_req_valid` and `wr_valid` are 0.
- R2: A store that misses allocates a line without any next-level read. Only its masked bytes become valid, and no two ways of a set ever hold the same tag.
- R3: A store that hits overwrites exactly the bytes selected by `st_mask` (bit b selects byte b of `st_data`, placed at line byte 8*`st_word`+b). All other bytes keep their value, so the latest store to a byte wins.
- R4: A victim whose 64 bytes are all valid is written out on the write port with no read request.
- R5: A partially valid victim issues a read of its line address. In the returned line, each byte whose valid flag is set is replaced by the buffered byte. The merged line is written in the cycle after the return.
- R6: A miss fills the lowest-numbered invalid way of the set. When all ways are valid, the victim is picked by a binary-tree pseudo-LRU in which every access points the nodes on its path away from the accessed way. For example, after accesses to ways 0,1,2,3 the victim is way 0, and after further accesses to 0 and then 1 it is way 2.
- R7: While an eviction is pending, `st_ready` is 0 for stores to the evicting set and for stores that would need another eviction. Stores to other sets that hit or find a free way are accepted, and with no eviction pending `st_ready` is 1.
- R8: `rd_req_valid` with `rd_req_line`, and `wr_valid` with `wr_line` and `wr_data`, stay asserted and unchanged until the matching ready is 1.
- R9: The set index is the low 3 bits of the line address. `rd_req_line` and `wr_line` carry the victim's full line address, and line byte k sits at bits 8k+7:8k of the line buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_line | input | 16 | Line address of the store |
| st_word | input | 3 | 8-byte word within the line |
| st_data | input | 64 | Store data, byte b at bits 8b+7:8b |
| st_mask | input | 8 | Byte enables for st_data |
| rd_req_valid | output | 1 | Next-level read request |
| rd_req_ready | input | 1 | Next level takes the read request |
| rd_req_line | output | 16 | Line address to read |
| rd_rsp_valid | input | 1 | Read data returning |
| rd_rsp_data | input | 512 | Returned line |
| wr_valid | output | 1 | Next-level line write |
| wr_ready | input | 1 | Next level takes the write |
| wr_line | output | 16 | Line address written |
| wr_data | output | 512 | Line data written |

## Verification
The bench keeps a byte-addressed reference of the latest value of every byte and a model of the next level. It compares every line written out against that reference. A merge that took the returned byte over a valid one, or that dropped a masked byte on a hit, would show up as a wrong byte. For each write-out, the bench also checks whether a read came first: a design that read on allocation, or that read for a fully written line, fails there. A directed fill of one set checks the exact victim order against the tree replacement. It also checks that a store to the evicting set is held off while a store to another set goes through. A long arithmetic sweep over 16 tags per set, with varying next-level delays, exercises the handshake hold and the stalls under load.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int WORD_BYTES = 8;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_READ  = 2'd1,
        EV_WAIT  = 2'd2,
        EV_WRITE = 2'd3
    } ev_state_e;
endpackage

// File: rtl/wsc_tag_match.sv
module wsc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 13,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAY_W-1:0]           hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[w] && (tags[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wsc_plru.sv
module wsc_plru #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:1]  tree,
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] touch,
    output logic [WAY_W-1:0] victim,
    output logic             full,
    output logic [WAYS-1:1]  tree_upd
);
    logic [WAY_W:0]   walk;
    logic [WAY_W:0]   climb;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        full     = &vld;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) free_way = WAY_W'(w);
        end
        walk = (WAY_W + 1)'(1);
        for (int l = 0; l < WAY_W; l++) begin
            walk = {walk[WAY_W-1:0], tree[walk[WAY_W-1:0]]};
        end
        victim = full ? walk[WAY_W-1:0] : free_way;
    end

    always_comb begin
        tree_upd = tree;
        climb    = {1'b1, touch};
        for (int l = 0; l < WAY_W; l++) begin
            tree_upd[climb[WAY_W:1]] = ~climb[0];
            climb = {1'b0, climb[WAY_W:1]};
        end
    end
endmodule

// File: rtl/wsc_byte_merge.sv
module wsc_byte_merge #(
    parameter int BYTES = 64
) (
    input  logic [BYTES*8-1:0] own_data,
    input  logic [BYTES-1:0]   own_vld,
    input  logic [BYTES*8-1:0] far_data,
    output logic [BYTES*8-1:0] merged
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = own_vld[b] ? own_data[b*8 +: 8] : far_data[b*8 +: 8];
    end
endmodule

// File: rtl/wsc_store_cache.sv
module wsc_store_cache
    import wsc_pkg::*;
#(
    parameter int LINE_BYTES  = 64,
    parameter int WAYS        = 4,
    parameter int SETS        = 8,
    parameter int LINE_ADDR_W = 16,
    localparam int WORDS      = LINE_BYTES / WORD_BYTES,
    localparam int WORD_IDX_W = $clog2(WORDS),
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [LINE_ADDR_W-1:0] st_line,
    input  logic [WORD_IDX_W-1:0]  st_word,
    input  logic [63:0]            st_data,
    input  logic [7:0]             st_mask,
    output logic                   rd_req_valid,
    input  logic                   rd_req_ready,
    output logic [LINE_ADDR_W-1:0] rd_req_line,
    input  logic                   rd_rsp_valid,
    input  logic [LINE_W-1:0]      rd_rsp_data,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [LINE_ADDR_W-1:0] wr_line,
    output logic [LINE_W-1:0]      wr_data
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = LINE_ADDR_W - SET_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        ev_state_e                                  ev_state;
        logic [SET_W-1:0]                           ev_set;
        logic [TAG_W-1:0]                           ev_tag;
        logic [LINE_BYTES-1:0]                      ev_bv;
        logic [LINE_W-1:0]                          ev_data;
        logic [SETS-1:0][WAYS-1:0]                  line_vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]       tags;
        logic [SETS-1:0][WAYS-1:0][LINE_BYTES-1:0]  bvld;
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0]      data;
        logic [SETS-1:0][WAYS-1:1]                  plru;
    } state_t;

    state_t st_q, st_d;

    logic [SET_W-1:0]      set_idx;
    logic [TAG_W-1:0]      tag_in;
    logic [WAYS-1:0]       hit_vec;
    logic [WAY_W-1:0]      hit_way;
    logic                  hit;
    logic [WAY_W-1:0]      victim_way;
    logic                  set_full;
    logic [WAY_W-1:0]      use_way;
    logic [WAYS-1:1]       tree_upd;
    logic                  need_evict;
    logic                  ev_busy;
    logic [LINE_W-1:0]     merged;
    logic [LINE_W-1:0]     line_new;
    logic [LINE_BYTES-1:0] bv_new;

    assign set_idx = st_line[SET_W-1:0];
    assign tag_in  = st_line[LINE_ADDR_W-1:SET_W];

    wsc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags    (st_q.tags[set_idx]),
        .vld     (st_q.line_vld[set_idx]),
        .tag     (tag_in),
        .hit_vec (hit_vec),
        .hit_way (hit_way)
    );

    assign hit     = |hit_vec;
    assign use_way = hit ? hit_way : victim_way;

    wsc_plru #(.WAYS(WAYS)) u_plru (
        .tree     (st_q.plru[set_idx]),
        .vld      (st_q.line_vld[set_idx]),
        .touch    (use_way),
        .victim   (victim_way),
        .full     (set_full),
        .tree_upd (tree_upd)
    );

    wsc_byte_merge #(.BYTES(LINE_BYTES)) u_merge (
        .own_data (st_q.ev_data),
        .own_vld  (st_q.ev_bv),
        .far_data (rd_rsp_data),
        .merged   (merged)
    );

    assign need_evict = !hit && set_full;
    assign ev_busy    = (st_q.ev_state != EV_IDLE);
    assign st_ready   = !ev_busy || ((set_idx != st_q.ev_set) && !need_evict);

    assign rd_req_valid = (st_q.ev_state == EV_READ);
    assign rd_req_line  = {st_q.ev_tag, st_q.ev_set};
    assign wr_valid     = (st_q.ev_state == EV_WRITE);
    assign wr_line      = {st_q.ev_tag, st_q.ev_set};
    assign wr_data      = st_q.ev_data;

    always_comb begin
        st_d     = st_q;
        line_new = hit ? st_q.data[set_idx][use_way] : '0;
        bv_new   = hit ? st_q.bvld[set_idx][use_way] : '0;
        for (int w = 0; w < WORDS; w++) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                if ((WORD_IDX_W'(w) == st_word) && st_mask[b]) begin
                    line_new[(w*WORD_BYTES+b)*8 +: 8] = st_data[b*8 +: 8];
                    bv_new[w*WORD_BYTES+b]            = 1'b1;
                end
            end
        end

        case (st_q.ev_state)
            EV_READ:  if (rd_req_ready) st_d.ev_state = EV_WAIT;
            EV_WAIT:  if (rd_rsp_valid) begin
                          st_d.ev_data  = merged;
                          st_d.ev_state = EV_WRITE;
                      end
            EV_WRITE: if (wr_ready) st_d.ev_state = EV_IDLE;
            default:  ;
        endcase

        if (st_valid && st_ready) begin
            if (need_evict) begin
                st_d.ev_set   = set_idx;
                st_d.ev_tag   = st_q.tags[set_idx][use_way];
                st_d.ev_bv    = st_q.bvld[set_idx][use_way];
                st_d.ev_data  = st_q.data[set_idx][use_way];
                st_d.ev_state = (&st_q.bvld[set_idx][use_way]) ? EV_WRITE : EV_READ;
            end
            st_d.line_vld[set_idx][use_way] = 1'b1;
            st_d.tags[set_idx][use_way]     = tag_in;
            st_d.bvld[set_idx][use_way]     = bv_new;
            st_d.data[set_idx][use_way]     = line_new;
            st_d.plru[set_idx]              = tree_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
    parameter int LINE_BYTES  = 64,
    parameter int WAYS        = 4,
    parameter int SET_W       = 3,
    parameter int LINE_ADDR_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic [SET_W-1:0]        st_set,
    input logic                    rd_req_valid,
    input logic                    rd_req_ready,
    input logic [LINE_ADDR_W-1:0]  rd_req_line,
    input logic                    rd_rsp_valid,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic [LINE_ADDR_W-1:0]  wr_line,
    input logic [LINE_BYTES*8-1:0] wr_data,
    input logic                    ev_busy,
    input logic [SET_W-1:0]        ev_set,
    input logic [LINE_BYTES-1:0]   ev_bv,
    input logic [WAYS-1:0]         hit_vec
);
    p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_no_read_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !(&ev_bv));

    p_write_after_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && !rd_req_valid && !wr_valid && rd_rsp_valid) |=> wr_valid);

    p_stall_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && st_valid && (st_set == ev_set)) |-> !st_ready);

    p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_busy |-> st_ready);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_line)));

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_line) && $stable(wr_data)));
endmodule

bind wsc_store_cache wsc_checker #(
    .LINE_BYTES  (LINE_BYTES),
    .WAYS        (WAYS),
    .SET_W       (SET_W),
    .LINE_ADDR_W (LINE_ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .st_set       (set_idx),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_line  (rd_req_line),
    .rd_rsp_valid (rd_rsp_valid),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_line      (wr_line),
    .wr_data      (wr_data),
    .ev_busy      (ev_busy),
    .ev_set       (st_q.ev_set),
    .ev_bv        (st_q.ev_bv),
    .hit_vec      (hit_vec)
);

// File: tb/tb_wsc_store_cache.sv
`timescale 1ns/1ps
module tb_wsc_store_cache;
    localparam int LA_W = 16;
    localparam int LB   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            st_valid = 1'b0;
    logic            st_ready;
    logic [LA_W-1:0] st_line = '0;
    logic [2:0]      st_word = '0;
    logic [63:0]     st_data = '0;
    logic [7:0]      st_mask = '0;
    logic            rd_req_valid;
    logic            rd_req_ready = 1'b0;
    logic [LA_W-1:0] rd_req_line;
    logic            rd_rsp_valid = 1'b0;
    logic [LB*8-1:0] rd_rsp_data = '0;
    logic            wr_valid;
    logic            wr_ready = 1'b0;
    logic [LA_W-1:0] wr_line;
    logic [LB*8-1:0] wr_data;

    always #2 clk = ~clk;

    wsc_store_cache dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
        .st_word(st_word), .st_data(st_data), .st_mask(st_mask),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_line(rd_req_line),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line), .wr_data(wr_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int rd_delay = 1;
    int wr_delay = 1;
    int wr_cnt = 0;
    int full_wr = 0;
    int part_wr = 0;
    bit rd_seen = 0;
    int rd_addr = 0;
    int last_wr_line = -1;
    bit last_wr_read = 0;

    logic [7:0]  refm  [int];
    logic [7:0]  nlm   [int];
    logic [63:0] wmask [int];

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 7) + (a >> 8) * 3 + 8'h5a);
    endfunction

    function automatic logic [7:0] ref_byte(int a);
        return refm.exists(a) ? refm[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] nl_byte(int a);
        return nlm.exists(a) ? nlm[a] : init_byte(a);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_ref(int line, int word, logic [63:0] d, logic [7:0] m);
        logic [63:0] wm;
        wm = wmask.exists(line) ? wmask[line] : 64'h0;
        for (int b = 0; b < 8; b++) begin
            if (m[b]) begin
                refm[line*LB + word*8 + b] = d[b*8 +: 8];
                wm[word*8 + b] = 1'b1;
            end
        end
        wmask[line] = wm;
    endtask

    task automatic do_store(int line, int word, logic [63:0] d, logic [7:0] m);
        @(negedge clk);
        st_valid = 1'b1;
        st_line  = LA_W'(line);
        st_word  = 3'(word);
        st_data  = d;
        st_mask  = m;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        st_valid = 1'b0;
        apply_ref(line, word, d, m);
    endtask

    // next-level read model
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_valid) begin
                int a;
                a = int'(rd_req_line);
                repeat (rd_delay) @(negedge clk);
                chk(int'(rd_req_line) == a, "R8", "read address held", rd_req_line, a);
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                rd_seen = 1'b1;
                rd_addr = a;
                @(negedge clk);
                for (int k = 0; k < LB; k++) rd_rsp_data[k*8 +: 8] = nl_byte(a*LB + k);
                rd_rsp_valid = 1'b1;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
            end
        end
    end

    // next-level write model and write-out checker
    initial begin
        forever begin
            @(negedge clk);
            if (wr_valid) begin
                int a;
                bit full;
                int bad;
                a = int'(wr_line);
                repeat (wr_delay) @(negedge clk);
                chk(int'(wr_line) == a, "R8", "write address held", wr_line, a);
                full = wmask.exists(a) && (wmask[a] == 64'hffff_ffff_ffff_ffff);
                chk(rd_seen == !full, "R4/R5", "read issued before write-out", rd_seen, !full);
                if (rd_seen) chk(rd_addr == a, "R5 R9", "read line address", rd_addr, a);
                bad = -1;
                for (int k = 0; k < LB; k++) begin
                    if (bad < 0 && wr_data[k*8 +: 8] !== ref_byte(a*LB + k)) bad = k;
                end
                if (bad < 0) chk(1'b1, "R2/R3/R5", "write-out data", 0, 0);
                else chk(1'b0, "R2/R3/R5", $sformatf("line %0h byte %0d", a, bad),
                         wr_data[bad*8 +: 8], ref_byte(a*LB + bad));
                for (int k = 0; k < LB; k++) nlm[a*LB + k] = wr_data[k*8 +: 8];
                if (full) full_wr++; else part_wr++;
                last_wr_line = a;
                last_wr_read = rd_seen;
                wmask.delete(a);
                rd_seen = 1'b0;
                wr_ready = 1'b1;
                @(negedge clk);
                wr_ready = 1'b0;
                wr_cnt++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_ready == 1'b1, "R1", "st_ready after reset", st_ready, 1);
        chk(rd_req_valid == 1'b0, "R1", "rd_req_valid after reset", rd_req_valid, 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);

        // fill set 0: line 8 full, lines 16/24/32 partial
        for (int w = 0; w < 8; w++) do_store(8, w, {32'h1111_0000 + w, 32'hcafe_0000 + w}, 8'hff);
        do_store(16, 2, 64'h0102_0304_0506_0708, 8'h0f);
        do_store(24, 2, 64'h1112_1314_1516_1718, 8'h0f);
        do_store(32, 2, 64'h2122_2324_2526_2728, 8'h0f);
        repeat (3) @(negedge clk);
        chk(wr_cnt == 0 && !rd_seen && !rd_req_valid, "R2", "no next-level traffic on allocation",
            wr_cnt, 0);

        wr_delay = 6;
        do_store(40, 0, 64'h55, 8'h01);
        // R7: same-set store stalls, other-set store proceeds
        @(negedge clk);
        st_valid = 1'b1; st_line = 48; st_word = 0; st_data = 64'h77; st_mask = 8'h01;
        #1 chk(st_ready == 1'b0, "R7", "store to evicting set (miss)", st_ready, 0);
        st_line = 16;
        #0.1 chk(st_ready == 1'b0, "R7", "store to evicting set (hit)", st_ready, 0);
        st_line = 17; st_data = 64'h99;
        #0.1 chk(st_ready == 1'b1, "R7", "store to other set with free way", st_ready, 1);
        @(posedge clk);
        #1 st_valid = 1'b0;
        apply_ref(17, 0, 64'h99, 8'h01);
        wait (wr_cnt == 1);
        chk(last_wr_line == 8, "R6", "first victim is oldest way", last_wr_line, 8);
        chk(last_wr_read == 1'b0, "R4", "full line written without read", last_wr_read, 0);

        wr_delay = 1;
        do_store(16, 2, 64'haaaa_bbbb_cccc_dddd, 8'hf0);
        do_store(48, 5, 64'h1234, 8'h03);
        wait (wr_cnt == 2);
        chk(last_wr_line == 24, "R6", "victim after hit follows tree", last_wr_line, 24);
        chk(last_wr_read == 1'b1, "R5", "partial line read before write", last_wr_read, 1);

        // arithmetic sweep over 16 tags per set
        for (int i = 0; i < 1500; i++) begin
            int line;
            logic [7:0] m;
            rd_delay = i % 4;
            wr_delay = i % 3;
            line = ((i * 13) ^ (i >> 2)) % 128;
            if (i % 64 == 0) begin
                for (int w = 0; w < 8; w++) do_store(line, w, {32'(i), 32'(w * 977)}, 8'hff);
            end else begin
                m = (i % 7 == 0) ? 8'hff : (8'((i * 37 + 11)) | 8'h01);
                do_store(line, (i * 5 + (i >> 4)) % 8, {32'(i * 32'h9e3779b1), ~32'(i)}, m);
            end
        end
        repeat (100) @(negedge clk);
        chk(full_wr > 0, "R4", "full-line write-outs seen", full_wr, 1);
        chk(part_wr > 0, "R5", "merged write-outs seen", part_wr, 1);
        chk(!rd_req_valid && !wr_valid && st_ready, "R7", "idle after drain", st_ready, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule